// File: doc/BRIEF.md
# Break-Before-Make Clock Route Change Sequencer

This block runs one clock route change as a managed event. A request brings a mask of the clock outputs it touches and the identifier of the new route. The sequencer first asks the application to enter a safe state and waits for it to agree. It then turns off the masked outputs and asks an external mapping table to commit the new route. After a settle interval given with the request, it turns the outputs back on and waits until every affected domain reports lock. Only then does it signal resume.

Every sequence ends with a one-cycle event record. The record holds the route id, the number of cycles spent waiting for lock, and a status code. Some sequences fail. If lock does not arrive in a bounded window, the sequencer breaks the outputs again, commits a fixed default route, settles and re-enables. If the table refuses the commit, or the application never acknowledges the safe-state request, the sequence stops with a matching status. The block holds neither the table nor the lock detectors. Both sit outside it.

Top module: `route_swap_seq`

## Requirements
- R1: After accepting a request, `quiesce_req` rises, and no output enable changes and no commit is requested until `quiesce_ack` is seen high.
- R2: `commit_req` is only ever high while every output in the active mask is disabled. `commit_route` carries the requested route id.
- R3: With `req_settle` = S, the masked outputs come back on at the S-th clock edge after the edge that samples `commit_ack`. With S = 0, they come back on at that same edge.
- R4: A normal sequence completes only once `lock_in` is high on every masked output. Lock bits of unmasked outputs are ignored. `resume` and `evt_valid` pulse together for one cycle.
- R5: The event record gives `evt_route` (the requested id), `evt_lock_time` and `evt_status`, encoded as 0 = done, 1 = lock timeout with rollback, 2 = commit rejected, 3 = quiesce timeout.
- R6: If full lock is missing for LOCK_TO consecutive wait cycles, the masked outputs are disabled again. A commit of DEFAULT_ROUTE is then requested, the settle interval is applied, and the outputs are re-enabled with status 1. Lock arriving in the last cycle of the window still completes with status 0.
- R7: A request that arrives while `busy` is high is refused. `req_refused` is high in that cycle, and the request is neither queued nor allowed to alter the running sequence.
- R8: `evt_lock_time` is the number of wait cycles before the cycle in which full lock is seen. It saturates at 2^LT_W-1.
- R9: A commit answered with `commit_nok` re-enables the masked outputs with status 2. With no `quiesce_ack` for Q_TO cycles, the sequence ends with status 3 and the outputs untouched.
- R10: Outputs outside the mask keep their enable state for the whole sequence.
- R11: After reset, all outputs are enabled, and `busy`, `quiesce_req`, `commit_req` and `evt_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Route change request strobe |
| req_mask | input | N_OUT | Outputs affected by the change |
| req_route | input | RID_W | Identifier of the requested route |
| req_settle | input | SET_W | Settle interval in cycles |
| busy | output | 1 | A sequence is in progress |
| req_refused | output | 1 | Request seen while busy and dropped |
| quiesce_req | output | 1 | Asks the application to hold a safe state |
| quiesce_ack | input | 1 | Application is in its safe state |
| out_en | output | N_OUT | Per-output clock enable |
| commit_req | output | 1 | Asks the table to apply `commit_route` |
| commit_route | output | RID_W | Route to commit |
| commit_ack | input | 1 | Table answered the commit |
| commit_nok | input | 1 | With `commit_ack`: the commit was refused |
| lock_in | input | N_OUT | Per-output downstream lock indication |
| resume | output | 1 | Application may leave its safe state |
| evt_valid | output | 1 | Event record valid |
| evt_route | output | RID_W | Route id of the finished sequence |
| evt_lock_time | output | LT_W | Cycles waited for lock, saturating |
| evt_status | output | 2 | Outcome code |

## Verification
Lock detection and the lock timeout can fall in the same cycle. The bench provokes this by holding the masked lock bits partly low, then completing them exactly LOCK_TO-1 cycles into the wait. It expects status 0 and a saturated lock time, not a rollback. A second case never completes lock. It expects the rollback commit to appear exactly LOCK_TO cycles into the wait, carrying the default route. The same bench also places a new request on the cycle a commit is answered, so that refusal and commit meet on one edge. It then checks that the commit, the mask and the event still belong to the original request.

// File: rtl/rss_pkg.sv
package rss_pkg;

  typedef enum logic [1:0] {
    ST_DONE     = 2'd0,
    ST_LOCK_TO  = 2'd1,
    ST_REJECT   = 2'd2,
    ST_QUIET_TO = 2'd3
  } rss_status_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_QUIESCE,
    PH_COMMIT,
    PH_SETTLE,
    PH_LOCKWAIT,
    PH_FINISH
  } rss_phase_e;

endpackage

// File: rtl/rss_phase_timer.sv
module rss_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expire
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (clr)                  cnt <= '0;
    else if (run && (cnt != '1))   cnt <= cnt + 1'b1;
  end

  // limit is never zero while run is high
  assign expire = run && (cnt == (limit - 1'b1));

endmodule

// File: rtl/rss_lock_meter.sv
module rss_lock_meter #(
  parameter int LT_W    = 8,
  parameter int LOCK_TO = 400
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            run,
  input  logic            locked,
  output logic [LT_W-1:0] lat,
  output logic            timeout
);

  localparam int TW = $clog2(LOCK_TO + 1);

  function automatic logic [LT_W-1:0] sat_inc(input logic [LT_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  logic [TW-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat      <= '0;
      wait_cnt <= '0;
    end else if (clr) begin
      lat      <= '0;
      wait_cnt <= '0;
    end else if (run && !locked) begin
      lat      <= sat_inc(lat);
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

  // lock has priority over the window end in the same cycle
  assign timeout = run && !locked && (wait_cnt == TW'(LOCK_TO - 1));

endmodule

// File: rtl/route_swap_seq.sv
module route_swap_seq
  import rss_pkg::*;
#(
  parameter int N_OUT         = 8,
  parameter int RID_W         = 6,
  parameter int LT_W          = 8,
  parameter int SET_W         = 8,
  parameter int LOCK_TO       = 400,
  parameter int Q_TO          = 32,
  parameter int DEFAULT_ROUTE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [N_OUT-1:0] req_mask,
  input  logic [RID_W-1:0] req_route,
  input  logic [SET_W-1:0] req_settle,
  output logic             busy,
  output logic             req_refused,
  output logic             quiesce_req,
  input  logic             quiesce_ack,
  output logic [N_OUT-1:0] out_en,
  output logic             commit_req,
  output logic [RID_W-1:0] commit_route,
  input  logic             commit_ack,
  input  logic             commit_nok,
  input  logic [N_OUT-1:0] lock_in,
  output logic             resume,
  output logic             evt_valid,
  output logic [RID_W-1:0] evt_route,
  output logic [LT_W-1:0]  evt_lock_time,
  output logic [1:0]       evt_status
);

  localparam int QW    = $clog2(Q_TO + 1);
  localparam int TMR_W = (SET_W > QW) ? SET_W : QW;

  function automatic logic group_locked(input logic [N_OUT-1:0] lk,
                                        input logic [N_OUT-1:0] mk);
    return &(lk | ~mk);
  endfunction

  rss_phase_e       phase, phase_nx;
  logic [N_OUT-1:0] act_mask;
  logic [RID_W-1:0] act_route;
  logic [SET_W-1:0] act_settle;
  logic             rollback;
  logic [N_OUT-1:0] out_en_q;

  // named internal events
  logic             w_accept;
  logic             w_drop;
  logic             w_raise;
  logic             w_fin;
  logic             w_group_locked;
  logic             w_tmr_expire;
  logic             w_lock_expire;
  rss_status_e      fin_status;
  logic [TMR_W-1:0] tmr_limit;
  logic [LT_W-1:0]  lock_lat;

  assign w_accept       = (phase == PH_IDLE) && req_valid;
  assign w_group_locked = group_locked(lock_in, act_mask);
  assign tmr_limit      = (phase == PH_SETTLE) ? TMR_W'(act_settle) : TMR_W'(Q_TO);

  rss_phase_timer #(.W(TMR_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (phase != phase_nx),
    .run    ((phase == PH_QUIESCE) || (phase == PH_COMMIT) || (phase == PH_SETTLE)),
    .limit  (tmr_limit),
    .expire (w_tmr_expire)
  );

  rss_lock_meter #(.LT_W(LT_W), .LOCK_TO(LOCK_TO)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     ((phase_nx == PH_LOCKWAIT) && (phase != PH_LOCKWAIT)),
    .run     (phase == PH_LOCKWAIT),
    .locked  (w_group_locked),
    .lat     (lock_lat),
    .timeout (w_lock_expire)
  );

  always_comb begin
    phase_nx   = phase;
    w_drop     = 1'b0;
    w_raise    = 1'b0;
    w_fin      = 1'b0;
    fin_status = ST_DONE;
    case (phase)
      PH_IDLE: if (req_valid) phase_nx = PH_QUIESCE;
      PH_QUIESCE: begin
        if (quiesce_ack) begin
          w_drop   = 1'b1;
          phase_nx = PH_COMMIT;
        end else if (w_tmr_expire) begin
          w_fin      = 1'b1;
          fin_status = ST_QUIET_TO;
          phase_nx   = PH_FINISH;
        end
      end
      PH_COMMIT: begin
        if ((commit_ack && commit_nok) || (!commit_ack && w_tmr_expire)) begin
          w_raise    = 1'b1;
          w_fin      = 1'b1;
          fin_status = rollback ? ST_LOCK_TO : ST_REJECT;
          phase_nx   = PH_FINISH;
        end else if (commit_ack) begin
          if (act_settle == '0) begin
            w_raise = 1'b1;
            if (rollback) begin
              w_fin      = 1'b1;
              fin_status = ST_LOCK_TO;
              phase_nx   = PH_FINISH;
            end else begin
              phase_nx = PH_LOCKWAIT;
            end
          end else begin
            phase_nx = PH_SETTLE;
          end
        end
      end
      PH_SETTLE: begin
        if (w_tmr_expire) begin
          w_raise = 1'b1;
          if (rollback) begin
            w_fin      = 1'b1;
            fin_status = ST_LOCK_TO;
            phase_nx   = PH_FINISH;
          end else begin
            phase_nx = PH_LOCKWAIT;
          end
        end
      end
      PH_LOCKWAIT: begin
        if (w_group_locked) begin
          w_fin      = 1'b1;
          fin_status = ST_DONE;
          phase_nx   = PH_FINISH;
        end else if (w_lock_expire) begin
          w_drop   = 1'b1;
          phase_nx = PH_COMMIT;
        end
      end
      PH_FINISH: phase_nx = PH_IDLE;
      default:   phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      act_mask   <= '0;
      act_route  <= '0;
      act_settle <= '0;
      rollback   <= 1'b0;
      out_en_q   <= '1;
    end else begin
      phase <= phase_nx;
      if (w_accept) begin
        act_mask   <= req_mask;
        act_route  <= req_route;
        act_settle <= req_settle;
        rollback   <= 1'b0;
      end else if ((phase == PH_LOCKWAIT) && w_drop) begin
        rollback <= 1'b1;
      end
      if (w_drop)       out_en_q <= out_en_q & ~act_mask;
      else if (w_raise) out_en_q <= out_en_q | act_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_route     <= '0;
      evt_lock_time <= '0;
      evt_status    <= 2'd0;
    end else if (w_fin) begin
      evt_route     <= act_route;
      evt_status    <= fin_status;
      evt_lock_time <= ((fin_status == ST_DONE) || (fin_status == ST_LOCK_TO)) ? lock_lat : '0;
    end
  end

  assign out_en       = out_en_q;
  assign busy         = (phase != PH_IDLE);
  assign req_refused  = req_valid && busy;
  assign quiesce_req  = (phase != PH_IDLE) && (phase != PH_FINISH);
  assign commit_req   = (phase == PH_COMMIT);
  assign commit_route = rollback ? RID_W'(DEFAULT_ROUTE) : act_route;
  assign evt_valid    = (phase == PH_FINISH);
  assign resume       = (phase == PH_FINISH);

endmodule

// File: rtl/rss_checker.sv
module rss_checker #(
  parameter int N_OUT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             busy,
  input logic             quiesce_req,
  input logic             commit_req,
  input logic [N_OUT-1:0] out_en,
  input logic [N_OUT-1:0] act_mask,
  input logic [N_OUT-1:0] lock_in,
  input logic             evt_valid,
  input logic [1:0]       evt_status
);

  p_drop_in_safe_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~out_en & $past(out_en))) |-> ($past(quiesce_req) && quiesce_req));

  p_break_before_make_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |-> ((out_en & act_mask) == '0));

  p_lock_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (evt_status == 2'd0)) |-> $past((lock_in & act_mask) == act_mask));

  p_refuse_keeps_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && busy) |=> $stable(act_mask));

  p_unmasked_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ((out_en & ~act_mask) == ($past(out_en) & ~act_mask)));

endmodule

bind route_swap_seq rss_checker #(.N_OUT(N_OUT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .busy        (busy),
  .quiesce_req (quiesce_req),
  .commit_req  (commit_req),
  .out_en      (out_en),
  .act_mask    (act_mask),
  .lock_in     (lock_in),
  .evt_valid   (evt_valid),
  .evt_status  (evt_status)
);

// File: tb/route_swap_seq_tb.sv
module route_swap_seq_tb;

  localparam int LOCK_TO = 400;
  localparam int Q_TO    = 32;
  localparam int DEF_RT  = 0;
  localparam int WD      = 150000;

  typedef struct packed {
    logic [7:0]  mask;
    logic [5:0]  route;
    logic [7:0]  settle;
    logic [7:0]  qdly;
    logic        q_never;
    logic        reject;
    logic        lock_never;
    logic        poke;
    logic [11:0] lockd;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{8'h0F, 6'd5,  8'd3,  8'd2, 1'b0, 1'b0, 1'b0, 1'b0, 12'd4},
    '{8'h80, 6'd9,  8'd0,  8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 12'd0},
    '{8'h3C, 6'd17, 8'd10, 8'd6, 1'b0, 1'b1, 1'b0, 1'b0, 12'd0},
    '{8'hFF, 6'd33, 8'd1,  8'd1, 1'b0, 1'b0, 1'b0, 1'b0, 12'd399},
    '{8'h81, 6'd12, 8'd2,  8'd0, 1'b0, 1'b0, 1'b1, 1'b0, 12'd0},
    '{8'h18, 6'd40, 8'd4,  8'd0, 1'b1, 1'b0, 1'b0, 1'b0, 12'd0},
    '{8'h42, 6'd63, 8'd5,  8'd3, 1'b0, 1'b0, 1'b0, 1'b1, 12'd7},
    '{8'h01, 6'd2,  8'd2,  8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 12'd255}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [7:0] req_mask = '0;
  logic [5:0] req_route = '0;
  logic [7:0] req_settle = '0;
  logic       busy, req_refused, quiesce_req;
  logic       quiesce_ack = 1'b0;
  logic [7:0] out_en;
  logic       commit_req;
  logic [5:0] commit_route;
  logic       commit_ack = 1'b0;
  logic       commit_nok = 1'b0;
  logic [7:0] lock_in = '0;
  logic       resume, evt_valid;
  logic [5:0] evt_route;
  logic [7:0] evt_lock_time;
  logic [1:0] evt_status;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  route_swap_seq #(
    .N_OUT(8), .RID_W(6), .LT_W(8), .SET_W(8),
    .LOCK_TO(LOCK_TO), .Q_TO(Q_TO), .DEFAULT_ROUTE(DEF_RT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mask(req_mask),
    .req_route(req_route), .req_settle(req_settle), .busy(busy),
    .req_refused(req_refused), .quiesce_req(quiesce_req), .quiesce_ack(quiesce_ack),
    .out_en(out_en), .commit_req(commit_req), .commit_route(commit_route),
    .commit_ack(commit_ack), .commit_nok(commit_nok), .lock_in(lock_in),
    .resume(resume), .evt_valid(evt_valid), .evt_route(evt_route),
    .evt_lock_time(evt_lock_time), .evt_status(evt_status)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input vec_t v);
    logic [7:0] prior;
    logic [7:0] partial;
    int k;
    int exp_lt;
    prior   = out_en;
    partial = v.mask & (v.mask - 8'd1);
    req_valid = 1'b1; req_mask = v.mask; req_route = v.route; req_settle = v.settle;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy && quiesce_req, "R1", "quiesce request after accept", int'(quiesce_req), 1);
    k = 0;
    while (!commit_req && !evt_valid && k < 1000) begin
      if (!v.q_never && k == int'(v.qdly)) quiesce_ack = 1'b1;
      if (k == 0) check((out_en == prior) && !commit_req, "R1", "no change before ack",
                        int'(out_en), int'(prior));
      @(negedge clk);
      k++;
    end
    if (v.q_never) begin
      check(evt_valid && evt_status == 2'd3, "R9", "quiesce timeout status", int'(evt_status), 3);
      check(k == Q_TO, "R9", "quiesce timeout cycles", k, Q_TO);
      check(out_en == prior, "R9", "outputs untouched on quiesce timeout", int'(out_en), int'(prior));
      check(evt_route == v.route, "R5", "event route", int'(evt_route), int'(v.route));
    end else begin
      check((out_en & v.mask) == 8'h00, "R2", "masked outputs off at commit", int'(out_en & v.mask), 0);
      check((out_en & ~v.mask) == (prior & ~v.mask), "R10", "unmasked outputs kept",
            int'(out_en), int'(prior));
      check(commit_route == v.route, "R2", "commit route", int'(commit_route), int'(v.route));
      if (v.poke) begin
        req_valid = 1'b1; req_route = ~v.route; req_mask = 8'hFF;
        #1;
        check(req_refused == 1'b1, "R7", "refusal flag while busy", int'(req_refused), 1);
      end
      commit_ack = 1'b1; commit_nok = v.reject;
      @(negedge clk);
      commit_ack = 1'b0; commit_nok = 1'b0; req_valid = 1'b0;
      k = 1;
      if (v.reject) begin
        check(evt_valid && evt_status == 2'd2, "R9", "reject status", int'(evt_status), 2);
        check((out_en & v.mask) == v.mask, "R9", "re-enable after reject", int'(out_en), int'(v.mask));
      end else begin
        while (((out_en & v.mask) != v.mask) && k < 1000) begin
          @(negedge clk);
          k++;
        end
        check(k == int'(v.settle) + 1, "R3", "settle interval", k, int'(v.settle) + 1);
        check((out_en & ~v.mask) == (prior & ~v.mask), "R10", "unmasked outputs after enable",
              int'(out_en), int'(prior));
        lock_in = ~v.mask | partial;
        if (!v.lock_never) begin
          repeat (int'(v.lockd)) @(negedge clk);
          check(!evt_valid, "R4", "no completion on partial lock", int'(evt_valid), 0);
          lock_in = v.mask;
          @(negedge clk);
          exp_lt = (int'(v.lockd) > 255) ? 255 : int'(v.lockd);
          check(evt_valid && resume, "R4", "resume with event", int'(resume), 1);
          check(evt_status == 2'd0, "R5", "done status", int'(evt_status), 0);
          check(int'(evt_lock_time) == exp_lt, "R8", "lock time", int'(evt_lock_time), exp_lt);
          check(evt_route == v.route, "R5", "event route", int'(evt_route), int'(v.route));
          if (v.poke) check(out_en == (prior | v.mask), "R7", "refused mask had no effect",
                            int'(out_en), int'(prior | v.mask));
        end else begin
          k = 0;
          while (!commit_req && k < 2000) begin
            @(negedge clk);
            k++;
          end
          check(k == LOCK_TO, "R6", "timeout window length", k, LOCK_TO);
          check(commit_route == 6'(DEF_RT), "R6", "rollback route", int'(commit_route), DEF_RT);
          check((out_en & v.mask) == 8'h00, "R6", "outputs broken before rollback",
                int'(out_en & v.mask), 0);
          commit_ack = 1'b1;
          @(negedge clk);
          commit_ack = 1'b0;
          k = 0;
          while (!evt_valid && k < 100) begin
            @(negedge clk);
            k++;
          end
          check(evt_status == 2'd1, "R6", "rollback status", int'(evt_status), 1);
          check(evt_lock_time == 8'd255, "R8", "lock time saturated on timeout", int'(evt_lock_time), 255);
          check((out_en & v.mask) == v.mask, "R6", "re-enable after rollback", int'(out_en), int'(v.mask));
          check(evt_route == v.route, "R5", "event route on rollback", int'(evt_route), int'(v.route));
        end
        lock_in = '0;
      end
    end
    quiesce_ack = 1'b0;
    @(negedge clk);
    check(!busy && !quiesce_req, "R7", "idle after event", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_en == 8'hFF, "R11", "reset enables", int'(out_en), 255);
    check(!busy && !quiesce_req && !commit_req && !evt_valid, "R11", "reset idle",
          int'(busy), 0);
    for (int i = 0; i < NV; i++) run_case(VEC[i]);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", WD, WD);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule